// File: doc/BRIEF.md
# Conversion Window Monitor

This block watches a stream of converter results and raises a sticky out-of-window flag when a result lands below a low limit or above a high limit. Each result arrives with a one-cycle valid strobe, the raw unaligned sample, the channel it came from, and a tag that marks it as a regular or injected conversion. The 8-bit limits are compared with the most significant 8 bits of the sample at the resolution currently configured. Because of this, the limits keep the same meaning whatever output alignment is chosen later.

Monitoring is switched on separately for each of the two conversion groups. A mode input chooses between watching every channel and watching only one selected channel. The selected channel applies to both groups. The flag stays set until a clear pulse arrives. An interrupt request is formed by gating the flag with an interrupt enable.

Top module: `awd_monitor`

## Requirements
- R1: A qualifying result whose 8-bit compare value is below `thr_lo_i` or above `thr_hi_i` sets `wd_flag_o` on the clock edge that samples `res_valid_i`. The flag is visible from the next cycle.
- R2: A compare value equal to either limit, or lying between the limits, does not set the flag.
- R3: The compare value depends on `res_sel_i`. Code 0 (12-bit) uses `res_data_i[11:4]`. Code 1 (10-bit) uses `res_data_i[9:2]`. Code 2 (8-bit) uses `res_data_i[7:0]`. Code 3 (6-bit) uses `{res_data_i[5:0],2'b00}`. Sample bits above the selected resolution are ignored.
- R4: A result tagged regular (`res_inj_i`=0) is monitored only while `mon_reg_en_i`=1. A result tagged injected (`res_inj_i`=1) is monitored only while `mon_inj_en_i`=1. With both enables low, the flag never sets.
- R5: With `single_ch_i`=0, results from any channel number are monitored.
- R6: With `single_ch_i`=1, only results whose `res_chan_i` equals `sel_chan_i` are monitored. This applies to regular and injected results alike.
- R7: With `single_ch_i`=1, a `sel_chan_i` value of 18 to 31 matches no channel, so no result is monitored.
- R8: The flag holds until a `flag_clr_i` pulse, which drops it in the next cycle. If a clear and a qualifying out-of-window result arrive in the same cycle, the set wins.
- R9: `irq_o` equals `wd_flag_o` AND `irq_en_i` combinationally, with no added cycle.
- R10: After reset, `wd_flag_o` and `irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| res_valid_i | input | 1 | One-cycle strobe marking a finished conversion |
| res_data_i | input | 12 | Raw right-justified sample |
| res_chan_i | input | 5 | Channel number of the sample |
| res_inj_i | input | 1 | 1 = injected conversion, 0 = regular |
| res_sel_i | input | 2 | Resolution code (0:12, 1:10, 2:8, 3:6 bits) |
| thr_lo_i | input | 8 | Low limit |
| thr_hi_i | input | 8 | High limit |
| mon_reg_en_i | input | 1 | Monitor regular conversions |
| mon_inj_en_i | input | 1 | Monitor injected conversions |
| single_ch_i | input | 1 | 1 = watch only the selected channel |
| sel_chan_i | input | 5 | Selected channel |
| flag_clr_i | input | 1 | Clear pulse for the flag |
| irq_en_i | input | 1 | Interrupt enable |
| wd_flag_o | output | 1 | Sticky out-of-window flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 12-bit sample, 8-bit limits, a 5-bit channel field and 18 valid channels. These defaults put all four resolution codes within reach, including the 6-bit code whose compare value is zero-padded at the bottom. Because the channel field can encode 32 values and only 18 are valid, out-of-range selections 18 to 31 can also be driven. Random limits that sometimes come reversed and random samples exercise both window edges. Directed vectors then hit exact-limit samples, stray upper bits, a clear that collides with a set, and every combination of group enables.

// File: rtl/awd_pkg.sv
package awd_pkg;
  typedef enum logic [1:0] {
    RES_12 = 2'd0,
    RES_10 = 2'd1,
    RES_8  = 2'd2,
    RES_6  = 2'd3
  } res_sel_e;

  localparam int unsigned RES_STEP = 2;  // bits lost per resolution code step
endpackage

// File: rtl/awd_align.sv
module awd_align
  import awd_pkg::*;
#(
  parameter int unsigned RES_W = 12,
  parameter int unsigned THR_W = 8
) (
  input  res_sel_e            res_sel_i,
  input  logic [RES_W-1:0]    data_i,
  output logic [THR_W-1:0]    top_o
);
  localparam int unsigned SH_W = $clog2(RES_W) + 1;

  logic [SH_W-1:0]  drop;
  logic [RES_W-1:0] masked;
  logic [RES_W-1:0] shifted;

  always_comb begin
    drop    = SH_W'(res_sel_i) * SH_W'(RES_STEP);
    // discard bits above the active resolution, then left-justify
    masked  = data_i & ({RES_W{1'b1}} >> drop);
    shifted = masked << drop;
    top_o   = shifted[RES_W-1 -: THR_W];
  end
endmodule

// File: rtl/awd_filter.sv
module awd_filter #(
  parameter int unsigned CH_W   = 5,
  parameter int unsigned NUM_CH = 18
) (
  input  logic            valid_i,
  input  logic [CH_W-1:0] chan_i,
  input  logic            inj_i,
  input  logic            reg_en_i,
  input  logic            inj_en_i,
  input  logic            single_i,
  input  logic [CH_W-1:0] sel_i,
  output logic            qual_o
);
  logic sel_ok, chan_ok, grp_ok;

  always_comb begin
    sel_ok  = (sel_i < CH_W'(NUM_CH));
    chan_ok = !single_i || (sel_ok && (chan_i == sel_i));
    grp_ok  = inj_i ? inj_en_i : reg_en_i;
    qual_o  = valid_i && grp_ok && chan_ok;
  end
endmodule

// File: rtl/awd_window.sv
module awd_window #(
  parameter int unsigned THR_W = 8
) (
  input  logic [THR_W-1:0] val_i,
  input  logic [THR_W-1:0] lo_i,
  input  logic [THR_W-1:0] hi_i,
  output logic             out_o
);
  // limits themselves count as inside
  assign out_o = (val_i < lo_i) || (val_i > hi_i);
endmodule

// File: rtl/awd_monitor.sv
module awd_monitor
  import awd_pkg::*;
#(
  parameter int unsigned RES_W  = 12,
  parameter int unsigned THR_W  = 8,
  parameter int unsigned CH_W   = 5,
  parameter int unsigned NUM_CH = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             res_valid_i,
  input  logic [RES_W-1:0] res_data_i,
  input  logic [CH_W-1:0]  res_chan_i,
  input  logic             res_inj_i,
  input  logic [1:0]       res_sel_i,
  input  logic [THR_W-1:0] thr_lo_i,
  input  logic [THR_W-1:0] thr_hi_i,
  input  logic             mon_reg_en_i,
  input  logic             mon_inj_en_i,
  input  logic             single_ch_i,
  input  logic [CH_W-1:0]  sel_chan_i,
  input  logic             flag_clr_i,
  input  logic             irq_en_i,
  output logic             wd_flag_o,
  output logic             irq_o
);
  logic [THR_W-1:0] top_val;
  logic             qual;
  logic             outside;
  logic             hit;
  logic             flag_q;

  awd_align #(.RES_W(RES_W), .THR_W(THR_W)) u_align (
    .res_sel_i (res_sel_e'(res_sel_i)),
    .data_i    (res_data_i),
    .top_o     (top_val)
  );

  awd_filter #(.CH_W(CH_W), .NUM_CH(NUM_CH)) u_filter (
    .valid_i  (res_valid_i),
    .chan_i   (res_chan_i),
    .inj_i    (res_inj_i),
    .reg_en_i (mon_reg_en_i),
    .inj_en_i (mon_inj_en_i),
    .single_i (single_ch_i),
    .sel_i    (sel_chan_i),
    .qual_o   (qual)
  );

  awd_window #(.THR_W(THR_W)) u_window (
    .val_i (top_val),
    .lo_i  (thr_lo_i),
    .hi_i  (thr_hi_i),
    .out_o (outside)
  );

  assign hit = qual && outside;

  // set has priority over clear so a new excursion is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         flag_q <= 1'b0;
    else if (hit)        flag_q <= 1'b1;
    else if (flag_clr_i) flag_q <= 1'b0;
  end

  assign wd_flag_o = flag_q;
  assign irq_o     = flag_q && irq_en_i;

  a_r1_set_on_excursion: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual && outside |=> wd_flag_o);

  a_r2_inside_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wd_flag_o && !(qual && outside) |=> !wd_flag_o);

  a_r4_idle_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mon_reg_en_i && !mon_inj_en_i && !wd_flag_o |=> !wd_flag_o);

  a_r7_bad_sel_blind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    single_ch_i && (sel_chan_i >= CH_W'(NUM_CH)) && !wd_flag_o |=> !wd_flag_o);

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_flag_o && !flag_clr_i |=> wd_flag_o);

  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr_i && !qual |=> !wd_flag_o);

  a_r9_irq_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> wd_flag_o && irq_en_i);
endmodule

// File: tb/awd_monitor_test.sv
`timescale 1ns/1ps
module awd_monitor_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [11:0] data = '0;
  logic [4:0]  chan = '0;
  logic        inj = 1'b0;
  logic [1:0]  rsel = '0;
  logic [7:0]  lo = '0;
  logic [7:0]  hi = '0;
  logic        reg_en = 1'b0;
  logic        inj_en = 1'b0;
  logic        single = 1'b0;
  logic [4:0]  sel = '0;
  logic        clr = 1'b0;
  logic        irq_en = 1'b0;
  logic        flag, irq;

  int unsigned vectors = 0;
  int unsigned errors = 0;

  always #2.5 clk = ~clk;

  awd_monitor uut (
    .clk_i(clk), .rst_ni(rst_n), .res_valid_i(valid), .res_data_i(data),
    .res_chan_i(chan), .res_inj_i(inj), .res_sel_i(rsel), .thr_lo_i(lo),
    .thr_hi_i(hi), .mon_reg_en_i(reg_en), .mon_inj_en_i(inj_en),
    .single_ch_i(single), .sel_chan_i(sel), .flag_clr_i(clr),
    .irq_en_i(irq_en), .wd_flag_o(flag), .irq_o(irq)
  );

  function automatic logic [7:0] top8(logic [11:0] d, logic [1:0] r);
    case (r)
      2'd0:    return d[11:4];
      2'd1:    return d[9:2];
      2'd2:    return d[7:0];
      default: return {d[5:0], 2'b00};
    endcase
  endfunction

  function automatic logic exp_hit(logic [11:0] d, logic [4:0] c, logic ij);
    logic [7:0] v = top8(d, rsel);
    logic grp = ij ? inj_en : reg_en;
    logic ch  = !single || ((sel < 5'd18) && (c == sel));
    return grp && ch && ((v < lo) || (v > hi));
  endfunction

  task automatic chk(logic act, logic exp, string req);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_clear();
    @(negedge clk); clr = 1'b1; valid = 1'b0;
    @(negedge clk); clr = 1'b0;
    chk(flag, 1'b0, "R8 clear");
  endtask

  task automatic send(logic [11:0] d, logic [4:0] c, logic ij);
    @(negedge clk); data = d; chan = c; inj = ij; valid = 1'b1;
    @(negedge clk); valid = 1'b0;
  endtask

  task automatic set_cfg(logic re, logic ie, logic sg, logic [4:0] sc,
                         logic [1:0] r, logic [7:0] l, logic [7:0] h);
    reg_en = re; inj_en = ie; single = sg; sel = sc; rsel = r; lo = l; hi = h;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1f3a));
    repeat (3) @(negedge clk);
    chk(flag, 1'b0, "R10 flag reset");
    chk(irq, 1'b0, "R10 irq reset");
    rst_n = 1'b1;
    irq_en = 1'b1;

    // R2 exact limits inside
    set_cfg(1, 1, 0, 0, 2'd0, 8'h40, 8'hC0);
    send(12'h40F, 5'd3, 0); chk(flag, 1'b0, "R2 equal low");
    send(12'hC0F, 5'd3, 0); chk(flag, 1'b0, "R2 equal high");
    // R1 one below low
    send(12'h3FF, 5'd3, 0); chk(flag, 1'b1, "R1 below low");
    chk(irq, 1'b1, "R9 irq on");
    @(negedge clk); irq_en = 1'b0; #1;
    chk(irq, 1'b0, "R9 irq gated");
    irq_en = 1'b1; #1;
    chk(irq, 1'b1, "R9 irq same cycle");
    // R8 sticky across inside result
    send(12'h800, 5'd3, 0); chk(flag, 1'b1, "R8 sticky");
    do_clear();
    // R1 one above high
    send(12'hC10, 5'd1, 0); chk(flag, 1'b1, "R1 above high");
    do_clear();
    // R8 set wins over clear
    @(negedge clk); data = 12'h000; chan = 5'd0; inj = 0; valid = 1'b1; clr = 1'b1;
    @(negedge clk); valid = 1'b0; clr = 1'b0;
    chk(flag, 1'b1, "R8 set beats clear");
    do_clear();

    // R3 6-bit mode ignores upper bits: 0xFC1 -> 6'h01 -> 8'h04
    set_cfg(1, 0, 0, 0, 2'd3, 8'h04, 8'h04);
    send(12'hFC1, 5'd2, 0); chk(flag, 1'b0, "R3 6-bit masked");
    send(12'hFC2, 5'd2, 0); chk(flag, 1'b1, "R3 6-bit above");
    do_clear();
    // R3 10-bit: 0xFFF -> 0xFF inside when hi=FF
    set_cfg(1, 0, 0, 0, 2'd1, 8'hFF, 8'hFF);
    send(12'hFFF, 5'd2, 0); chk(flag, 1'b0, "R3 10-bit top");
    // R3 8-bit: 0xF7F -> 0x7F below
    set_cfg(1, 0, 0, 0, 2'd2, 8'h80, 8'hFF);
    send(12'hF7F, 5'd2, 0); chk(flag, 1'b1, "R3 8-bit low byte");
    do_clear();

    // R4 group enables
    set_cfg(1, 0, 0, 0, 2'd0, 8'h40, 8'h80);
    send(12'hFFF, 5'd4, 1); chk(flag, 1'b0, "R4 injected off");
    set_cfg(0, 1, 0, 0, 2'd0, 8'h40, 8'h80);
    send(12'hFFF, 5'd4, 0); chk(flag, 1'b0, "R4 regular off");
    set_cfg(0, 0, 0, 0, 2'd0, 8'h40, 8'h80);
    send(12'hFFF, 5'd4, 1); chk(flag, 1'b0, "R4 both off");
    send(12'h000, 5'd4, 0); chk(flag, 1'b0, "R4 both off reg");
    set_cfg(0, 1, 0, 0, 2'd0, 8'h40, 8'h80);
    send(12'hFFF, 5'd4, 1); chk(flag, 1'b1, "R4 injected on");
    do_clear();

    // R5 all channels incl. 17
    set_cfg(1, 1, 0, 5'd0, 2'd0, 8'h40, 8'h80);
    send(12'h000, 5'd17, 0); chk(flag, 1'b1, "R5 any channel");
    do_clear();
    // R6 single channel in both groups
    set_cfg(1, 1, 1, 5'd5, 2'd0, 8'h40, 8'h80);
    send(12'h000, 5'd6, 0); chk(flag, 1'b0, "R6 other channel");
    send(12'h000, 5'd6, 1); chk(flag, 1'b0, "R6 other channel inj");
    send(12'h000, 5'd5, 1); chk(flag, 1'b1, "R6 selected inj");
    do_clear();
    send(12'h000, 5'd5, 0); chk(flag, 1'b1, "R6 selected reg");
    do_clear();
    // R7 out-of-range selection
    set_cfg(1, 1, 1, 5'd18, 2'd0, 8'h40, 8'h80);
    send(12'h000, 5'd18, 0); chk(flag, 1'b0, "R7 sel 18");
    set_cfg(1, 1, 1, 5'd31, 2'd0, 8'h40, 8'h80);
    send(12'hFFF, 5'd31, 1); chk(flag, 1'b0, "R7 sel 31");

    // random vectors
    for (int i = 0; i < 300; i++) begin
      logic [11:0] d;
      logic [4:0]  c;
      logic        ij, e;
      logic [7:0]  a, b;
      do_clear();
      a = 8'($urandom); b = 8'($urandom);
      if ($urandom_range(0, 3) != 0 && a > b) begin
        logic [7:0] t = a; a = b; b = t;
      end
      set_cfg(1'($urandom), 1'($urandom), 1'($urandom),
              5'($urandom_range(0, 20)), 2'($urandom), a, b);
      irq_en = 1'($urandom);
      d  = 12'($urandom);
      c  = ($urandom_range(0, 1) == 0) ? sel : 5'($urandom_range(0, 19));
      ij = 1'($urandom);
      e  = exp_hit(d, c, ij);
      send(d, c, ij);
      chk(flag, e, "R1 R2 R3 R4 R6 random");
      chk(irq, e & irq_en, "R9 random");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule